// File: doc/BRIEF.md
# Multimode Reloadable Timer

A 32-bit timer with a small word-addressed register interface. Software loads a count, a reload compare value and a secondary (PWM/capture) value. It then sets a control word that picks one of eight counting modes, a clock prescaler and the polarity of the external pin, and turns the timer on. The counter advances on prescaled ticks. In most modes it restarts at one, not zero, when it meets the compare value, and that event raises a sticky interrupt request.

The eight modes cover several uses. There are single-run and free-running interval timing and counting of external pin edges. There is pulse-width output, where the output asserts at the PWM value and releases at the reload. Capture of the running count on a pin edge is offered with or without restart. A compare mode lets the counter run past the match and wrap. A gated mode counts only while the pin is at its active level. The external pin passes through a two-flop synchronizer before any use.

Top module: `mm_timer`

## Requirements
- R1: Word offsets (byte address, low two bits zero): 0x00 count, 0x04 reload compare, 0x08 PWM/capture, 0x0C interrupt flag (bit 0; a write of any value clears it), 0x10 control (bits [8:0] stored, higher bits read 0), 0x14 and all other offsets read 0 and ignore writes.
- R2: Control bit 7 is the enable. While it is 0 the count holds its value.
- R3: In every mode except compare, an advance with count equal to the reload compare loads the count with 1 and sets the interrupt flag.
- R4: With control bit 8 clear, control bits [5:3] = k make the counter advance once every 2^k clocks (or qualifying pin edges in counter mode). The first advance comes 2^k clocks after the enabling write.
- R5: With control bit 8 set, codes 0, 2, 3, 4, 5 in bits [5:3] divide by 256, 512, 1024, 2048, 4096. Codes 1, 6, 7 divide by 4096.
- R6: Mode 0 (one-shot): at the match the output asserts, the enable bit clears and counting stops.
- R7: Mode 1 (continuous): the output toggles at every match and counting goes on.
- R8: Mode 3 (PWM): an advance with count equal to the PWM value asserts the output. The reload match releases it.
- R9: Mode 2 (counter): only qualifying pin edges (rising when bit 6 is 0, falling when 1) advance the count. The count updates three clocks after the pin change.
- R10: Mode 6 (gated): the count advances on each prescaled tick while the synchronized pin is at its active level.
- R11: Modes 4 (capture) and 7 (capture with restart): a qualifying pin edge copies the count into the PWM register and sets the flag. Mode 7 also loads the count with 1.
- R12: Mode 5 (compare): the match sets the flag and toggles the output but does not reload. The count wraps from 0xFFFFFFFF to 0.
- R13: The interrupt flag stays set until a write to offset 0x0C. If a set and a clear fall on the same cycle, the set wins.
- R14: The output pin equals the internal output state XOR control bit 6. A control write that turns the enable from 0 to 1 returns the output to its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tmr_in | input | 1 | External timer pin (asynchronous) |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt request level |

## Verification
A wrong prescaler state shows as a count read that is off by one at a tick boundary exactly 2^k clocks after enable. A broken reload or wrap shows on the next count read after the match cycle. A bad synchronizer or edge detector shifts the capture value or the counter-mode increment by a clock, or adds a spurious one. This is seen three cycles after a pin change. Output-state and flag errors appear on tmr_out and irq one clock after the match, capture or clearing write.

// File: rtl/mm_timer_pkg.sv
package mm_timer_pkg;

    localparam int CTRL_W  = 9;
    localparam int SHIFT_W = 4;

    typedef enum logic [2:0] {
        M_ONCE  = 3'd0,
        M_CONT  = 3'd1,
        M_EVCNT = 3'd2,
        M_PWM   = 3'd3,
        M_CAPT  = 3'd4,
        M_CMPR  = 3'd5,
        M_GATE  = 3'd6,
        M_CAPRL = 3'd7
    } tmr_mode_e;

    // bit 8 ext, bit 7 enable, bit 6 polarity, bits 5:3 divider code, bits 2:0 mode
    typedef struct packed {
        logic      ext;
        logic      en;
        logic      pol;
        logic [2:0] code;
        tmr_mode_e mode;
    } ctrl_t;

    // log2 of the prescale ratio
    function automatic logic [SHIFT_W-1:0] div_shift(input logic ext, input logic [2:0] code);
        logic [SHIFT_W-1:0] s;
        if (!ext) begin
            s = {1'b0, code};
        end else begin
            case (code)
                3'd0:    s = 4'd8;
                3'd2:    s = 4'd9;
                3'd3:    s = 4'd10;
                3'd4:    s = 4'd11;
                default: s = 4'd12;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/mm_timer_sync.sv
module mm_timer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    output logic lvl_act,
    output logic edge_act
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        lvl_act   = st_q.sh[STAGES-1] ^ pol;
        edge_act  = lvl_act & ~st_q.prev;
        st_d.sh   = {st_q.sh[STAGES-2:0], pin};
        st_d.prev = lvl_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // an active edge never repeats on the following cycle unless polarity flips
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_act && $stable(pol)) |=> !edge_act);  // R9

endmodule

// File: rtl/mm_timer_presc.sv
module mm_timer_presc #(
    parameter int PRE_W   = 12,
    parameter int SHIFT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               step,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);

    localparam int LIM_W = PRE_W + 1;

    logic [PRE_W-1:0] acc_d, acc_q;
    logic [LIM_W-1:0] lim;

    always_comb begin
        lim   = (LIM_W'(1) << shift) - LIM_W'(1);
        tick  = run && step && ({1'b0, acc_q} >= lim);
        acc_d = acc_q;
        if (!run)      acc_d = '0;
        else if (tick) acc_d = '0;
        else if (step) acc_d = acc_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // the accumulator restarts from zero whenever the timer is stopped
    AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run)) |-> (acc_q == '0));  // R4

endmodule

// File: rtl/mm_timer.sv
module mm_timer
    import mm_timer_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 5,
    parameter int PRE_W   = 12,
    parameter int SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic              tmr_in,
    output logic              tmr_out,
    output logic              irq
);

    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] pwm;
        ctrl_t            ctrl;
        logic             pin;
        logic             flag;
    } state_t;

    state_t st_d, st_q;

    logic             lvl_act, edge_act, step, tick, hit, cap;
    logic             wr_cnt, wr_cmp, wr_pwm, wr_clr, wr_ctl, aligned;
    logic [IDX_W-1:0] widx;
    ctrl_t            new_ctl;
    logic             flag_set;

    mm_timer_sync #(.STAGES(SYNC_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (tmr_in),
        .pol      (st_q.ctrl.pol),
        .lvl_act  (lvl_act),
        .edge_act (edge_act)
    );

    mm_timer_presc #(.PRE_W(PRE_W), .SHIFT_W(SHIFT_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.ctrl.en),
        .step  (step),
        .shift (div_shift(st_q.ctrl.ext, st_q.ctrl.code)),
        .tick  (tick)
    );

    always_comb begin
        aligned = (reg_addr[1:0] == 2'b00);
        widx    = reg_addr[ADDR_W-1:2];
        wr_cnt  = reg_wr && aligned && (widx == IDX_W'(0));
        wr_cmp  = reg_wr && aligned && (widx == IDX_W'(1));
        wr_pwm  = reg_wr && aligned && (widx == IDX_W'(2));
        wr_clr  = reg_wr && aligned && (widx == IDX_W'(3));
        wr_ctl  = reg_wr && aligned && (widx == IDX_W'(4));
        new_ctl = ctrl_t'(reg_wdata[CTRL_W-1:0]);

        case (st_q.ctrl.mode)
            M_EVCNT: step = edge_act;
            M_GATE:  step = lvl_act;
            default: step = 1'b1;
        endcase

        hit = (st_q.cnt == st_q.cmp);
        cap = st_q.ctrl.en && edge_act &&
              ((st_q.ctrl.mode == M_CAPT) || (st_q.ctrl.mode == M_CAPRL));

        st_d = st_q;
        if (tick) begin
            if (hit) begin
                case (st_q.ctrl.mode)
                    M_CMPR: begin st_d.cnt = st_q.cnt + CNT_W'(1); st_d.pin = ~st_q.pin; end
                    M_PWM:  begin st_d.cnt = CNT_W'(1); st_d.pin = 1'b0; end
                    M_ONCE: begin st_d.cnt = CNT_W'(1); st_d.pin = 1'b1; st_d.ctrl.en = 1'b0; end
                    default: begin st_d.cnt = CNT_W'(1); st_d.pin = ~st_q.pin; end
                endcase
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
                if ((st_q.ctrl.mode == M_PWM) && (st_q.cnt == st_q.pwm)) st_d.pin = 1'b1;
            end
        end
        if (cap) begin
            st_d.pwm = st_q.cnt;
            if (st_q.ctrl.mode == M_CAPRL) st_d.cnt = CNT_W'(1);
        end

        flag_set  = (tick && hit) || cap;
        st_d.flag = flag_set || (st_q.flag && !wr_clr);

        if (wr_cnt) st_d.cnt = reg_wdata;
        if (wr_cmp) st_d.cmp = reg_wdata;
        if (wr_pwm) st_d.pwm = reg_wdata;
        if (wr_ctl) begin
            st_d.ctrl = new_ctl;
            if (new_ctl.en && !st_q.ctrl.en) st_d.pin = 1'b0;
        end

        case (widx)
            IDX_W'(0): reg_rdata = st_q.cnt;
            IDX_W'(1): reg_rdata = st_q.cmp;
            IDX_W'(2): reg_rdata = st_q.pwm;
            IDX_W'(3): reg_rdata = {{(CNT_W-1){1'b0}}, st_q.flag};
            IDX_W'(4): reg_rdata = {{(CNT_W-CTRL_W){1'b0}}, st_q.ctrl};
            default:   reg_rdata = '0;
        endcase
        if (!aligned) reg_rdata = '0;

        tmr_out = st_q.pin ^ st_q.ctrl.pol;
        irq     = st_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.en && !wr_cnt) |=> (st_q.cnt == $past(st_q.cnt)));  // R2

    AST_RELOAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hit && (st_q.ctrl.mode != M_CMPR) && !wr_cnt) |=> (st_q.cnt == CNT_W'(1) && irq));  // R3

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hit && (st_q.ctrl.mode == M_ONCE) && !wr_ctl) |=> !st_q.ctrl.en);  // R6

    AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !wr_pwm) |=> (st_q.pwm == $past(st_q.cnt) && irq));  // R11

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_clr) |=> irq);  // R13

endmodule

// File: tb/sim_mm_timer.sv
`timescale 1ns/1ps
module sim_mm_timer;

    localparam logic [2:0] WR = 3'd0, RD = 3'd1, WT = 3'd2, IN = 3'd3, PN = 3'd4;
    localparam logic [7:0] A_CNT = 8'h00, A_CMP = 8'h04, A_PWM = 8'h08,
                           A_CLR = 8'h0C, A_CTL = 8'h10, A_NOL = 8'h14, Z = 8'h00;
    localparam int N = 183;

    // {requirement, op, address, data}
    localparam logic [46:0] TBL [0:N-1] = '{
        // R7 continuous, divide by 1; R3 reload to one with flag
        {4'd7, WR, A_CMP, 32'd4}, {4'd7, WR, A_CNT, 32'd1}, {4'd7, WR, A_CTL, 32'h81},
        {4'd7, RD, A_CNT, 32'd1}, {4'd7, WT, Z, 32'd1}, {4'd7, RD, A_CNT, 32'd2},
        {4'd7, WT, Z, 32'd2}, {4'd7, RD, A_CNT, 32'd4}, {4'd7, PN, Z, 32'd0},
        {4'd7, WT, Z, 32'd1}, {4'd3, RD, A_CNT, 32'd1}, {4'd7, PN, Z, 32'd3},
        {4'd3, RD, A_CLR, 32'd1},
        // R13 clear by write, R7 second toggle
        {4'd13, WR, A_CLR, 32'd0}, {4'd13, RD, A_CLR, 32'd0}, {4'd13, PN, Z, 32'd1},
        {4'd7, WT, Z, 32'd3}, {4'd7, PN, Z, 32'd2},
        // R2 disabled hold
        {4'd2, WR, A_CTL, 32'h01}, {4'd2, WR, A_CLR, 32'd0}, {4'd2, RD, A_CNT, 32'd2},
        {4'd2, WT, Z, 32'd10}, {4'd2, RD, A_CNT, 32'd2},
        // R4 divide by 4
        {4'd4, WR, A_CNT, 32'd1}, {4'd4, WR, A_CTL, 32'h91}, {4'd4, WT, Z, 32'd3},
        {4'd4, RD, A_CNT, 32'd1}, {4'd4, WT, Z, 32'd1}, {4'd4, RD, A_CNT, 32'd2},
        {4'd4, WT, Z, 32'd4}, {4'd4, RD, A_CNT, 32'd3}, {4'd4, WR, A_CTL, 32'h11},
        // R5 extended: 256, undefined code 7 -> 4096, code 3 -> 1024
        {4'd5, WR, A_CMP, 32'hFFFFFFFF}, {4'd5, WR, A_CNT, 32'd1}, {4'd5, WR, A_CTL, 32'h181},
        {4'd5, WT, Z, 32'd255}, {4'd5, RD, A_CNT, 32'd1}, {4'd5, WT, Z, 32'd1},
        {4'd5, RD, A_CNT, 32'd2}, {4'd5, WR, A_CTL, 32'h101},
        {4'd5, WR, A_CNT, 32'd1}, {4'd5, WR, A_CTL, 32'h1B9}, {4'd5, WT, Z, 32'd4095},
        {4'd5, RD, A_CNT, 32'd1}, {4'd5, WT, Z, 32'd1}, {4'd5, RD, A_CNT, 32'd2},
        {4'd5, WR, A_CTL, 32'h139},
        {4'd5, WR, A_CNT, 32'd1}, {4'd5, WR, A_CTL, 32'h199}, {4'd5, WT, Z, 32'd1023},
        {4'd5, RD, A_CNT, 32'd1}, {4'd5, WT, Z, 32'd1}, {4'd5, RD, A_CNT, 32'd2},
        {4'd5, WR, A_CTL, 32'h000},
        // R6 one-shot with active-low output (R14)
        {4'd6, WR, A_CMP, 32'd3}, {4'd6, WR, A_CNT, 32'd1}, {4'd6, WR, A_CTL, 32'hC0},
        {4'd14, PN, Z, 32'd1}, {4'd6, WT, Z, 32'd3}, {4'd6, PN, Z, 32'd2},
        {4'd6, RD, A_CTL, 32'h40}, {4'd6, WT, Z, 32'd5}, {4'd6, RD, A_CNT, 32'd1},
        // R14 enable rise returns output inactive
        {4'd14, WR, A_CLR, 32'd0}, {4'd14, WR, A_CTL, 32'h00}, {4'd14, PN, Z, 32'd1},
        {4'd14, WR, A_CTL, 32'h80}, {4'd14, PN, Z, 32'd0}, {4'd14, WT, Z, 32'd3},
        {4'd14, PN, Z, 32'd3}, {4'd14, RD, A_CTL, 32'h00}, {4'd14, WR, A_CLR, 32'd0},
        // R8 PWM
        {4'd8, WR, A_CMP, 32'd6}, {4'd8, WR, A_PWM, 32'd3}, {4'd8, WR, A_CNT, 32'd1},
        {4'd8, WR, A_CTL, 32'h83}, {4'd8, WT, Z, 32'd2}, {4'd8, PN, Z, 32'd0},
        {4'd8, RD, A_CNT, 32'd3}, {4'd8, WT, Z, 32'd1}, {4'd8, PN, Z, 32'd1},
        {4'd8, RD, A_CNT, 32'd4}, {4'd8, WT, Z, 32'd3}, {4'd8, PN, Z, 32'd2},
        {4'd8, RD, A_CNT, 32'd1}, {4'd8, WR, A_CTL, 32'h03}, {4'd8, WR, A_CLR, 32'd0},
        // R9 counter mode, rising then falling edges
        {4'd9, WR, A_CMP, 32'hFFFF}, {4'd9, WR, A_CNT, 32'd10}, {4'd9, WR, A_CTL, 32'h82},
        {4'd9, WT, Z, 32'd3}, {4'd9, RD, A_CNT, 32'd10}, {4'd9, IN, Z, 32'd1},
        {4'd9, WT, Z, 32'd2}, {4'd9, RD, A_CNT, 32'd10}, {4'd9, WT, Z, 32'd1},
        {4'd9, RD, A_CNT, 32'd11}, {4'd9, IN, Z, 32'd0}, {4'd9, WT, Z, 32'd5},
        {4'd9, RD, A_CNT, 32'd11}, {4'd9, IN, Z, 32'd1}, {4'd9, WT, Z, 32'd3},
        {4'd9, RD, A_CNT, 32'd12}, {4'd9, IN, Z, 32'd0}, {4'd9, WT, Z, 32'd3},
        {4'd9, WR, A_CTL, 32'h42}, {4'd9, WR, A_CTL, 32'hC2}, {4'd9, IN, Z, 32'd1},
        {4'd9, WT, Z, 32'd3}, {4'd9, RD, A_CNT, 32'd12}, {4'd9, IN, Z, 32'd0},
        {4'd9, WT, Z, 32'd3}, {4'd9, RD, A_CNT, 32'd13}, {4'd9, WR, A_CTL, 32'h02},
        // R10 gated
        {4'd10, WR, A_CNT, 32'd1}, {4'd10, WR, A_CTL, 32'h86}, {4'd10, WT, Z, 32'd4},
        {4'd10, RD, A_CNT, 32'd1}, {4'd10, IN, Z, 32'd1}, {4'd10, WT, Z, 32'd5},
        {4'd10, RD, A_CNT, 32'd4}, {4'd10, IN, Z, 32'd0}, {4'd10, WT, Z, 32'd5},
        {4'd10, RD, A_CNT, 32'd6}, {4'd10, WR, A_CTL, 32'h06},
        // R11 capture, then capture with restart
        {4'd11, WR, A_CMP, 32'hFFFFFFFF}, {4'd11, WR, A_CNT, 32'd1}, {4'd11, WR, A_CTL, 32'h84},
        {4'd11, IN, Z, 32'd1}, {4'd11, WT, Z, 32'd3}, {4'd11, RD, A_PWM, 32'd3},
        {4'd11, PN, Z, 32'd2}, {4'd11, RD, A_CNT, 32'd4}, {4'd11, WR, A_CTL, 32'h04},
        {4'd11, IN, Z, 32'd0}, {4'd11, WR, A_CLR, 32'd0}, {4'd11, WT, Z, 32'd3},
        {4'd11, WR, A_CNT, 32'd1}, {4'd11, WR, A_CTL, 32'h87}, {4'd11, IN, Z, 32'd1},
        {4'd11, WT, Z, 32'd3}, {4'd11, RD, A_PWM, 32'd3}, {4'd11, RD, A_CNT, 32'd1},
        {4'd11, PN, Z, 32'd2}, {4'd11, WT, Z, 32'd2}, {4'd11, RD, A_CNT, 32'd3},
        {4'd11, WR, A_CTL, 32'h07}, {4'd11, IN, Z, 32'd0}, {4'd11, WR, A_CLR, 32'd0},
        {4'd11, WT, Z, 32'd3},
        // R12 compare: no reload, wrap to zero
        {4'd12, WR, A_CMP, 32'd3}, {4'd12, WR, A_CNT, 32'd2}, {4'd12, WR, A_CTL, 32'h85},
        {4'd12, WT, Z, 32'd2}, {4'd12, RD, A_CNT, 32'd4}, {4'd12, PN, Z, 32'd3},
        {4'd12, WR, A_CTL, 32'h05}, {4'd12, WR, A_CLR, 32'd0}, {4'd12, WR, A_CNT, 32'hFFFFFFFE},
        {4'd12, WR, A_CMP, 32'd5}, {4'd12, WR, A_CTL, 32'h85}, {4'd12, WT, Z, 32'd2},
        {4'd12, RD, A_CNT, 32'd0}, {4'd12, PN, Z, 32'd0}, {4'd12, WR, A_CTL, 32'h05},
        // R13 set beats clear in the same cycle
        {4'd13, WR, A_CMP, 32'd2}, {4'd13, WR, A_CNT, 32'd1}, {4'd13, WR, A_CTL, 32'h81},
        {4'd13, WT, Z, 32'd1}, {4'd13, WR, A_CLR, 32'd0}, {4'd13, RD, A_CLR, 32'd1},
        {4'd13, WR, A_CTL, 32'h01}, {4'd13, WR, A_CLR, 32'd0}, {4'd13, RD, A_CLR, 32'd0},
        // R1 map, masking and ignored offsets
        {4'd1, WR, A_NOL, 32'h1234}, {4'd1, RD, A_NOL, 32'd0}, {4'd1, RD, A_CMP, 32'd2},
        {4'd1, WR, A_CTL, 32'hFFFFFE05}, {4'd1, RD, A_CTL, 32'h005}, {4'd1, WR, A_PWM, 32'hA5A5},
        {4'd1, RD, A_PWM, 32'hA5A5}, {4'd1, RD, A_CNT, 32'd2}, {4'd1, RD, 8'h18, 32'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tmr_in = 1'b0;
    logic        tmr_out, irq;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    mm_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tmr_in    (tmr_in),
        .tmr_out   (tmr_out),
        .irq       (irq)
    );

    task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd_chk(input int req, input logic [7:0] addr, input logic [31:0] exp);
        reg_addr = addr[4:0];
        #1;
        check(req, $sformatf("read @%02h", addr), reg_rdata, exp);
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] data);
        reg_wr    = 1'b1;
        reg_addr  = addr[4:0];
        reg_wdata = data;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state: R1 registers, R14 output, R13 flag
        rd_chk(1, A_CNT, 32'd0);
        rd_chk(1, A_CTL, 32'd0);
        rd_chk(1, A_CLR, 32'd0);
        check(14, "out after reset", {31'd0, tmr_out}, 32'd0);
        check(13, "irq after reset", {31'd0, irq}, 32'd0);
        for (int i = 0; i < N; i++) begin
            case (TBL[i][42:40])
                WR: wr(TBL[i][39:32], TBL[i][31:0]);
                RD: rd_chk(int'(TBL[i][46:43]), TBL[i][39:32], TBL[i][31:0]);
                WT: repeat (int'(TBL[i][31:0])) @(negedge clk);
                IN: tmr_in = TBL[i][0];
                default: check(int'(TBL[i][46:43]), $sformatf("row %0d {irq,out}", i),
                               {30'd0, irq, tmr_out}, TBL[i][31:0]);
            endcase
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule